// File: doc/BRIEF.md
# Handshaked Periodic Interrupt Timer

This block produces a timed interrupt that software controls through a single 4-bit register. Accesses to the register arrive as decoded single-cycle read and write strobes. Timing advances on a 10 Hz tick pulse that a shared prescaler supplies.

Writing zero stops all timing and returns the logic to its unconditioned state. Software must then read the register three times before a non-zero code is accepted. A code selects the period and whether the timer is single-shot or repeating. When the period runs out, the interrupt output rises and stays high.

The service routine follows a fixed sequence of reads:
- the first read drops the interrupt;
- the second read re-conditions the logic;
- in repeating mode, a third read reloads the period and restarts timing.

A single-shot timer instead waits after the second read until software writes a new code.

Top module: `irq_timer`

## Requirements
- R1: After reset `irq_o` is low, `rdata_o` reads 4'b0000, and three reads are still needed before a code is accepted.
- R2: A write of 4'b0000 at any time drives `irq_o` low on the next cycle and stops timing. After it, three reads are required before a non-zero write is accepted.
- R3: A non-zero write made before the three conditioning reads are complete is ignored and starts no timing.
- R4: Code bits 2:0 select the period: 3'b100 is 600 ticks, 3'b010 is 50 ticks, and 3'b001 is 5 ticks. `irq_o` rises in the cycle after the tick that completes the period, and not earlier.
- R5: Any other value of bits 2:0 starts no timing. The logic stays conditioned, so a later valid code is accepted without new conditioning reads.
- R6: `irq_o` is active high and stays high until a read or a zero write. While it is high, reads return `rdata_o[0]`=1. `rdata_o[3:1]` always read 0.
- R7: The first read after the interrupt drives `irq_o` low on the next cycle. Ticks then cause no interrupt until the service sequence is complete.
- R8: Code bit 3 = 1 selects repeating mode. The third service read reloads the period, and `irq_o` rises again after that many further ticks.
- R9: Code bit 3 = 0 selects single-shot mode. After the clearing read and the conditioning read, no further interrupt occurs until a new non-zero write, which starts the period again.
- R10: A non-zero write while timing or while the interrupt is pending is ignored. The current period and the pending interrupt are unaffected.
- R11: Ticks that arrive while the logic is waiting for a code do not shorten the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 10 Hz timebase pulse |
| rd_i | input | 1 | One-cycle read strobe to the interrupt register |
| wr_i | input | 1 | One-cycle write strobe to the interrupt register |
| wdata_i | input | 4 | Write data: bit 3 repeat, bits 2:0 period |
| rdata_o | output | 4 | Read data: bit 0 interrupt pending |
| irq_o | output | 1 | Interrupt, active high, level-held |

## Verification
The assertions take for granted that a read and a write never share a cycle, and that each strobe and tick lasts exactly one cycle. The stimulus tasks raise one strobe or one tick per cycle pair and lower it before the next, so these conditions always hold. The tick is never raised in the same cycle as a strobe, which means an expiry never coincides with a clearing read.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int CODE_W  = 4;
  localparam int REP_BIT = 3;

  localparam logic [2:0] PER_LONG  = 3'b100;
  localparam logic [2:0] PER_MID   = 3'b010;
  localparam logic [2:0] PER_SHORT = 3'b001;

  typedef enum logic [2:0] {
    ST_COND  = 3'd0,
    ST_READY = 3'd1,
    ST_RUN   = 3'd2,
    ST_FIRE  = 3'd3,
    ST_SVC1  = 3'd4,
    ST_SVC2  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/it_period_dec.sv
module it_period_dec
  import irq_timer_pkg::*;
#(
  parameter int TICK_HZ = 10,
  parameter int CNT_W   = 10
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic              rep_o,
  output logic [CNT_W-1:0]  ticks_o
);
  localparam int T_LONG  = 60 * TICK_HZ;
  localparam int T_MID   = 5 * TICK_HZ;
  localparam int T_SHORT = TICK_HZ / 2;

  assign rep_o = code_i[REP_BIT];

  always_comb begin
    valid_o = 1'b1;
    unique case (code_i[2:0])
      PER_LONG:  ticks_o = CNT_W'(T_LONG);
      PER_MID:   ticks_o = CNT_W'(T_MID);
      PER_SHORT: ticks_o = CNT_W'(T_SHORT);
      default: begin
        valid_o = 1'b0;
        ticks_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/it_timer.sv
module it_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             arm_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] per_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (arm_i) begin
      per_q <= val_i;
      cnt_q <= val_i;
    end else if (restart_i) begin
      cnt_q <= per_q;
    end else if (run_i && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_i && tick_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/it_seq.sv
module it_seq
  import irq_timer_pkg::*;
#(
  parameter int COND_READS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_zero_i,
  input  logic code_valid_i,
  input  logic code_rep_i,
  input  logic expire_i,
  output logic run_o,
  output logic arm_o,
  output logic restart_o,
  output logic irq_o
);
  localparam int CC_W = $clog2(COND_READS + 1);

  seq_state_e        st_q, st_d;
  logic [CC_W-1:0]   cc_q, cc_d;
  logic              rep_q, rep_d;
  logic              irq_q, irq_d;

  always_comb begin
    st_d      = st_q;
    cc_d      = cc_q;
    rep_d     = rep_q;
    irq_d     = irq_q;
    arm_o     = 1'b0;
    restart_o = 1'b0;
    if (wr_i && wr_zero_i) begin
      st_d  = ST_COND;
      cc_d  = '0;
      irq_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_COND: if (rd_i) begin
          if (cc_q == CC_W'(COND_READS - 1)) st_d = ST_READY;
          else cc_d = cc_q + 1'b1;
        end
        ST_READY: if (wr_i && code_valid_i) begin
          arm_o = 1'b1;
          rep_d = code_rep_i;
          st_d  = ST_RUN;
        end
        ST_RUN: if (expire_i) begin
          irq_d = 1'b1;
          st_d  = ST_FIRE;
        end
        ST_FIRE: if (rd_i) begin
          irq_d = 1'b0;
          st_d  = ST_SVC1;
        end
        ST_SVC1: if (rd_i) st_d = rep_q ? ST_SVC2 : ST_READY;
        ST_SVC2: if (rd_i) begin
          restart_o = 1'b1;
          st_d      = ST_RUN;
        end
        default: st_d = ST_COND;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_COND;
      cc_q  <= '0;
      rep_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cc_q  <= cc_d;
      rep_q <= rep_d;
      irq_q <= irq_d;
    end
  end

  assign run_o = (st_q == ST_RUN);
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_timer.sv
module irq_timer
  import irq_timer_pkg::*;
#(
  parameter int TICK_HZ    = 10,
  parameter int COND_READS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(60 * TICK_HZ + 1);

  logic             code_valid, code_rep, expire, run, arm, restart;
  logic [CNT_W-1:0] code_ticks;

  it_period_dec #(.TICK_HZ(TICK_HZ), .CNT_W(CNT_W)) u_dec (
    .code_i (wdata_i),
    .valid_o(code_valid),
    .rep_o  (code_rep),
    .ticks_o(code_ticks)
  );

  it_seq #(.COND_READS(COND_READS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .wr_zero_i   (wdata_i == '0),
    .code_valid_i(code_valid),
    .code_rep_i  (code_rep),
    .expire_i    (expire),
    .run_o       (run),
    .arm_o       (arm),
    .restart_o   (restart),
    .irq_o       (irq_o)
  );

  it_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .arm_i    (arm),
    .restart_i(restart),
    .val_i    (code_ticks),
    .expire_o (expire)
  );

  assign rdata_o = {{(CODE_W-1){1'b0}}, irq_o};
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [3:0] wdata_i,
  input logic [3:0] rdata_o,
  input logic       irq_o
);
  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !rd_i && !(wr_i && wdata_i == 4'd0) |=> irq_o);

  // R7
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && rd_i && !wr_i |=> !irq_o);

  // R2
  zero_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i == 4'd0 |=> !irq_o);

  // R4
  irq_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i));

  // R6
  rdata_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> rdata_o[0] == irq_o && rdata_o[3:1] == 3'd0);

  // R7
  no_irq_on_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !$rose(irq_o));
endmodule

bind irq_timer irq_timer_chk u_chk (.*);

// File: tb/irq_timer_tb.sv
module irq_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] wdata = 4'd0;
  logic [3:0] rdata;
  logic       irq;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  irq_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {code, expected ticks}; 0 ticks means no timing
  localparam logic [15:0] VEC [9] = '{
    {4'h9, 12'd5},   {4'h1, 12'd5},   {4'h2, 12'd50},
    {4'hA, 12'd50},  {4'h4, 12'd600}, {4'h8, 12'd0},
    {4'h3, 12'd0},   {4'h7, 12'd0},   {4'hE, 12'd0}
  };

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] v);
    @(negedge clk); wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0; wdata = 4'd0;
  endtask

  task automatic do_rd(output logic [3:0] d);
    @(negedge clk); rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic init();
    logic [3:0] d;
    do_wr(4'd0);
    for (int i = 0; i < 3; i++) do_rd(d);
  endtask

  initial begin
    logic [3:0] d;
    int n;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(irq, 0, "R1 irq after reset");
    chk(rdata, 0, "R1 rdata after reset");
    do_wr(4'h1); ticks(10);
    chk(irq, 0, "R1 write before conditioning after reset");

    for (int v = 0; v < 9; v++) begin
      n = int'(VEC[v][11:0]);
      init();
      do_wr(VEC[v][15:12]);
      if (n == 0) begin
        ticks(700);
        chk(irq, 0, "R5 invalid period code");
        do_wr(4'h1); ticks(5);
        chk(irq, 1, "R5 valid code after invalid");
        do_rd(d); do_rd(d);
      end else begin
        ticks(n - 1);
        chk(irq, 0, "R4 irq before period end");
        ticks(1);
        chk(irq, 1, "R4 irq at period end");
        ticks(3);
        chk(irq, 1, "R6 irq level held");
        do_rd(d);
        chk(d, 4'h1, "R6 rdata pending flag");
        chk(irq, 0, "R7 first read clears");
        ticks(n + 2);
        chk(irq, 0, "R7 no irq during service");
        do_rd(d);
        if (VEC[v][15]) begin
          do_rd(d);
          ticks(n - 1);
          chk(irq, 0, "R8 repeat not early");
          ticks(1);
          chk(irq, 1, "R8 repeat restart");
          do_rd(d); do_rd(d); do_rd(d);
        end else begin
          ticks(n + 5);
          chk(irq, 0, "R9 single-shot stays idle");
          do_wr(VEC[v][15:12]);
          ticks(n);
          chk(irq, 1, "R9 single-shot rerun");
          do_rd(d); do_rd(d);
        end
      end
    end

    // R3: partial conditioning
    do_wr(4'd0); do_rd(d); do_rd(d);
    do_wr(4'h1); ticks(10);
    chk(irq, 0, "R3 write after two reads ignored");
    do_rd(d); do_wr(4'h1); ticks(5);
    chk(irq, 1, "R3 write after third read accepted");
    do_rd(d); do_rd(d);

    // R11: idle ticks do not pre-count
    ticks(20); do_wr(4'h1); ticks(4);
    chk(irq, 0, "R11 idle ticks ignored");
    ticks(1);
    chk(irq, 1, "R11 full period after idle ticks");
    do_rd(d); do_rd(d);

    // R10: write while running and while pending
    do_wr(4'h1); ticks(2); do_wr(4'h4); ticks(3);
    chk(irq, 1, "R10 write while running ignored");
    do_wr(4'h2);
    chk(irq, 1, "R10 write while pending ignored");
    do_rd(d); do_rd(d);

    // R2: zero write stops timing and clears irq
    do_wr(4'h9); ticks(3); do_wr(4'd0); ticks(10);
    chk(irq, 0, "R2 zero write stops timing");
    do_wr(4'h1); ticks(10);
    chk(irq, 0, "R2 reconditioning required");
    do_rd(d); do_rd(d); do_rd(d);
    do_wr(4'h9); ticks(5);
    chk(irq, 1, "R2 armed after reconditioning");
    do_wr(4'd0);
    chk(irq, 0, "R2 zero write clears irq");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule